// File: doc/BRIEF.md
# Weighted overlap-add channeliser front end

This block sits in front of a K-point FFT in a uniform filter-bank channeliser. It keeps the most recent L complex input samples in a delay line. Each time D new samples have arrived, it weights the whole line with a real prototype filter and folds the weighted line modulo K into one K-point vector. It then streams that vector out as a burst of K complex samples for the downstream transform. Because the weighting line is longer than the transform and is folded, the decimation D is independent of the FFT length K. The channel spacing is fs/K, the per-channel output rate is fs/D, and the parameters satisfy K/D = fdemod/Δf.

Phase correction is done in the time domain. Each burst is read out with a circular offset of (f·D) mod K, where f counts bursts since the block was started. The FFT outputs therefore need no per-frame rotation. When D is a multiple of K the offset stays zero.

The coefficients are loaded through a simple write port while the block is stopped. Input samples must be paced so that one frame of D samples spans at least K clock cycles. With that pacing, a burst always ends before the next frame completes.

Top module: `wola_front`

## Requirements
- R1: While `run` is high, each D-th accepted sample (`in_vld`) completes a frame. The first sample of that frame's burst appears in the clock cycle after the edge that accepted the frame's last sample. No burst appears at any other time.
- R2: Each burst is K consecutive cycles with `out_vld` high. `out_start` is high on the first of these cycles only.
- R3: With x[0] the newest sample and x[n] the sample n inputs older, the fold value for bin k (0 ≤ k < K) is the sum over m of h[k+mK]·x[k+mK], for m from 0 to L/K−1. The real and imaginary parts are each weighted by the same real coefficient h. Samples that are older than the history since `run` rose count as zero.
- R4: Each fold sum is rounded by adding 2^(CW−2) and shifting right arithmetically by CW−1. The result is saturated to a signed width of DW+log2(L/K) bits.
- R5: Burst number f (counting from 0 after `run` rises) outputs, at position j, the fold value of bin (j + f·D) mod K.
- R6: A write with `cfg_we` high stores `cfg_coef` (signed, CW bits) as h[`cfg_addr`] only while `run` is low. Writes while `run` is high are ignored.
- R7: While `run` is low, input samples are ignored and the delay line is cleared to zero. The frame count and the burst index return to zero, and any burst in progress stops, so `out_vld` is low from the next cycle on. After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: process samples; low: idle and accept coefficient writes |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | log2(L) | Coefficient index n |
| cfg_coef | input | CW | Signed coefficient h[n] |
| in_vld | input | 1 | Input sample valid |
| in_re | input | DW | Input sample, real part |
| in_im | input | DW | Input sample, imaginary part |
| out_start | output | 1 | First sample of a burst |
| out_vld | output | 1 | Burst sample valid |
| out_re | output | DW+log2(L/K) | Folded sample, real part |
| out_im | output | DW+log2(L/K) | Folded sample, imaginary part |

## Verification
The checker watches the framing on every cycle. It counts accepted samples on its own and requires a start exactly one cycle after every D-th sample. It also checks that a burst holds valid for K cycles, that the outputs fall quiet one cycle after `run` drops, and that the coefficient bank does not change while running. The numeric content of each burst can only be shown by the bench scenarios, which compare against an independent model. That content covers the fold sums, the rounding and positive saturation, the rotating read offset, the ignored write while running, and the fresh start after an aborted burst.

// File: rtl/wola_front.sv
module wola_front #(
  parameter int K  = 8,
  parameter int D  = 6,
  parameter int L  = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run,
  input  logic                              cfg_we,
  input  logic [$clog2(L)-1:0]              cfg_addr,
  input  logic signed [CW-1:0]              cfg_coef,
  input  logic                              in_vld,
  input  logic signed [DW-1:0]              in_re,
  input  logic signed [DW-1:0]              in_im,
  output logic                              out_start,
  output logic                              out_vld,
  output logic signed [DW+$clog2(L/K)-1:0]  out_re,
  output logic signed [DW+$clog2(L/K)-1:0]  out_im
);
  localparam int M   = L / K;
  localparam int GB  = $clog2(M);
  localparam int OW  = DW + GB;
  localparam int PW  = DW + CW;
  localparam int SW  = PW + GB;
  localparam int RW  = SW - CW + 1;
  localparam int AW  = $clog2(L);
  localparam int KW  = $clog2(K);
  localparam int CNW = $clog2(D);
  localparam logic [KW:0]         KV   = (KW+1)'(K);
  localparam logic [KW:0]         RDV  = (KW+1)'(D % K);
  localparam logic signed [SW-1:0] HALF = SW'(longint'(1) <<< (CW-2));

  logic signed [DW-1:0] dl_re [L];
  logic signed [DW-1:0] dl_im [L];
  logic signed [DW-1:0] sn_re [L];
  logic signed [DW-1:0] sn_im [L];
  logic [L-1:0][CW-1:0] coef;

  logic [CNW-1:0] scnt;
  logic           busy;
  logic [KW-1:0]  pos, rot, nrot, idx;
  logic [KW:0]    psum, rsum;
  logic           frame_end;

  logic signed [PW-1:0] pr_re [M];
  logic signed [PW-1:0] pr_im [M];
  logic signed [SW-1:0] acc_re, acc_im;

  assign frame_end = run && in_vld && (scnt == CNW'(D-1));
  assign psum      = {1'b0, pos} + {1'b0, rot};
  assign idx       = (psum >= KV) ? KW'(psum - KV) : psum[KW-1:0];
  assign rsum      = {1'b0, nrot} + RDV;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                coef <= '0;
    else if (cfg_we && !run)   coef[cfg_addr] <= cfg_coef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < L; n++) begin
        dl_re[n] <= '0;
        dl_im[n] <= '0;
        sn_re[n] <= '0;
        sn_im[n] <= '0;
      end
    end else if (!run) begin
      for (int n = 0; n < L; n++) begin
        dl_re[n] <= '0;
        dl_im[n] <= '0;
      end
    end else if (in_vld) begin
      dl_re[0] <= in_re;
      dl_im[0] <= in_im;
      for (int n = 1; n < L; n++) begin
        dl_re[n] <= dl_re[n-1];
        dl_im[n] <= dl_im[n-1];
      end
      if (frame_end) begin
        sn_re[0] <= in_re;
        sn_im[0] <= in_im;
        for (int n = 1; n < L; n++) begin
          sn_re[n] <= dl_re[n-1];
          sn_im[n] <= dl_im[n-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      busy <= 1'b0;
      pos  <= '0;
      rot  <= '0;
      nrot <= '0;
    end else if (!run) begin
      scnt <= '0;
      busy <= 1'b0;
      pos  <= '0;
      nrot <= '0;
    end else begin
      if (in_vld)
        scnt <= frame_end ? '0 : scnt + 1'b1;
      if (frame_end) begin
        busy <= 1'b1;
        pos  <= '0;
        rot  <= nrot;
        nrot <= (rsum >= KV) ? KW'(rsum - KV) : rsum[KW-1:0];
      end else if (busy) begin
        if (pos == KW'(K-1)) begin
          busy <= 1'b0;
          pos  <= '0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_tap
    logic [AW-1:0] tap;
    assign tap      = AW'(idx) + AW'(m * K);
    assign pr_re[m] = sn_re[tap] * $signed(coef[tap]);
    assign pr_im[m] = sn_im[tap] * $signed(coef[tap]);
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int m = 0; m < M; m++) begin
      acc_re = acc_re + SW'(pr_re[m]);
      acc_im = acc_im + SW'(pr_im[m]);
    end
  end

  function automatic logic signed [OW-1:0] rnd_sat(input logic signed [SW-1:0] a);
    logic signed [SW-1:0] t;
    logic signed [RW-1:0] r;
    t = a + HALF;
    r = t[SW-1:CW-1];
    if ((&r[RW-1:OW-1]) || !(|r[RW-1:OW-1]))
      rnd_sat = r[OW-1:0];
    else
      rnd_sat = {r[RW-1], {(OW-1){~r[RW-1]}}};
  endfunction

  assign out_vld   = busy;
  assign out_start = busy && (pos == '0);
  assign out_re    = rnd_sat(acc_re);
  assign out_im    = rnd_sat(acc_im);
endmodule

// File: rtl/wola_front_chk.sv
module wola_front_chk #(
  parameter int K  = 8,
  parameter int D  = 6,
  parameter int L  = 32,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            in_vld,
  input logic            out_start,
  input logic            out_vld,
  input logic [L*CW-1:0] coef
);
  int acnt;
  int bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt <= 0;
      bcnt <= 0;
    end else if (!run) begin
      acnt <= 0;
      bcnt <= 0;
    end else begin
      if (in_vld) acnt <= (acnt == D-1) ? 0 : acnt + 1;
      if (out_vld) bcnt <= out_start ? 1 : ((bcnt == K-1) ? 0 : bcnt + 1);
    end
  end

  p_frame_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && in_vld && acnt == D-1) |=> out_start);

  p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> $past(run && in_vld && acnt == D-1));

  p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_vld);

  p_burst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (bcnt != 0) |-> out_vld);

  p_burst_bound_r2: assert property (@(posedge clk) disable iff (!rst_n || !run)
    out_vld |-> (out_start || bcnt != 0));

  p_coef_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(coef));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_vld);
endmodule

bind wola_front wola_front_chk #(.K(K), .D(D), .L(L), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .in_vld(in_vld),
  .out_start(out_start), .out_vld(out_vld), .coef(coef)
);

// File: tb/test_wola_front.sv
module test_wola_front;
  localparam int CLK_PERIOD = 10;
  localparam int K  = 8;
  localparam int D  = 6;
  localparam int L  = 32;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int M  = L / K;
  localparam int OW = DW + $clog2(M);
  localparam int AW = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic signed [CW-1:0] cfg_coef = '0;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic out_start, out_vld;
  logic signed [OW-1:0] out_re, out_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  wola_front #(.K(K), .D(D), .L(L), .DW(DW), .CW(CW)) i_wola_front (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_coef(cfg_coef), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
    .out_start(out_start), .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  string tag = "R3";

  longint m_re [L];
  longint m_im [L];
  longint m_cf [L];
  int scnt = 0;
  int fidx = 0;
  longint q_re [$];
  longint q_im [$];
  bit     q_st [$];

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint rs(longint a);
    longint lim, t;
    lim = longint'(1) <<< (OW-1);
    t = (a + (longint'(1) <<< (CW-2))) >>> (CW-1);
    if (t > lim - 1) t = lim - 1;
    if (t < -lim) t = -lim;
    return t;
  endfunction

  function automatic void model_push(longint re, longint im);
    for (int n = L-1; n > 0; n--) begin
      m_re[n] = m_re[n-1];
      m_im[n] = m_im[n-1];
    end
    m_re[0] = re;
    m_im[0] = im;
    scnt++;
    if (scnt == D) begin
      int rot;
      scnt = 0;
      rot = (fidx * D) % K;
      for (int j = 0; j < K; j++) begin
        int idx;
        longint ar, ai;
        idx = (j + rot) % K;
        ar = 0;
        ai = 0;
        for (int m = 0; m < M; m++) begin
          ar += m_cf[idx + m*K] * m_re[idx + m*K];
          ai += m_cf[idx + m*K] * m_im[idx + m*K];
        end
        q_re.push_back(rs(ar));
        q_im.push_back(rs(ai));
        q_st.push_back(j == 0);
      end
      fidx++;
    end
  endfunction

  task automatic send(int re, int im, int gap);
    @(negedge clk);
    in_vld = 1'b1;
    in_re = DW'(re);
    in_im = DW'(im);
    @(posedge clk);
    #1;
    if (run) model_push(re, im);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wr(int a, int v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(a);
    cfg_coef = CW'(v);
    @(posedge clk);
    #1;
    if (!run) m_cf[a] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_run(bit v);
    @(negedge clk);
    run = v;
    @(posedge clk);
    #1;
    scnt = 0;
    fidx = 0;
    if (!v) begin
      q_re.delete();
      q_im.delete();
      q_st.delete();
      for (int n = 0; n < L; n++) begin
        m_re[n] = 0;
        m_im[n] = 0;
      end
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  // R1 R2 R3 R4 R5: every burst sample is compared to the model queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (q_re.size() == 0) begin
          chk(1'b0, "R1 out_vld without a completed frame", 1, 0);
        end else begin
          longint er, ei;
          bit es;
          er = q_re.pop_front();
          ei = q_im.pop_front();
          es = q_st.pop_front();
          chk(longint'(out_re) == er, {tag, " out_re"}, longint'(out_re), er);
          chk(longint'(out_im) == ei, {tag, " out_im"}, longint'(out_im), ei);
          chk(out_start == es, "R2 out_start position", longint'(out_start), longint'(es));
        end
      end else if (q_re.size() != 0) begin
        chk(1'b0, "R1 R2 burst sample missing", 0, 1);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < L; n++) begin
      m_re[n] = 0;
      m_im[n] = 0;
      m_cf[n] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && !out_start, "R7 outputs low after reset", longint'(out_vld), 0);
    mon_on = 1;

    // R6: coefficients load while idle
    for (int a = 0; a < L; a++) wr(a, rnd16());

    // R7: samples offered while idle leave no trace
    for (int i = 0; i < D + 1; i++) send(rnd16(), rnd16(), 0);
    chk(!out_vld, "R7 no burst while idle", longint'(out_vld), 0);

    set_run(1'b1);
    tag = "R3 R5";
    for (int f = 0; f < 10; f++) begin
      for (int s = 0; s < D; s++) begin
        send(rnd16(), rnd16(), int'($urandom_range(2)));
        if (f == 4 && s == 2) begin
          wr(3, 12345);
          tag = "R3 R5 R6";
        end
      end
    end
    repeat (K + 2) @(negedge clk);
    chk(q_re.size() == 0, "R1 all bursts delivered", q_re.size(), 0);

    // R7: stop in the middle of a burst and with a partial frame pending
    for (int s = 0; s < D + 2; s++) send(rnd16(), rnd16(), 0);
    set_run(1'b0);
    @(negedge clk);
    chk(!out_vld, "R7 burst aborted when run drops", longint'(out_vld), 0);

    // R4: positive saturation once the line is full of the most negative value
    for (int a = 0; a < L; a++) wr(a, -32768);
    set_run(1'b1);
    tag = "R4";
    for (int i = 0; i < 6 * D; i++) send(-32768, (i % 2 == 0) ? 32767 : -32768, 0);
    repeat (K + 2) @(negedge clk);
    chk(q_re.size() == 0, "R4 saturation bursts delivered", q_re.size(), 0);

    // R5: distinct ramp coefficients expose the read offset of each burst
    set_run(1'b0);
    for (int a = 0; a < L; a++) wr(a, (a + 1) * 256);
    set_run(1'b1);
    tag = "R5 rotation";
    for (int i = 0; i < 5 * D; i++) send(i * 100 + 7, -i * 50, 1);
    repeat (K + 2) @(negedge clk);
    chk(q_re.size() == 0, "R5 rotation bursts delivered", q_re.size(), 0);

    summary();
    $finish;
  end
endmodule